// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This unit sits in front of a single-port word memory and serves several requesting ports, one operation at a time. Besides plain loads and stores it carries out three indivisible operations: exchange, test-and-set and fetch-and-increment. Every operation hands back the value the addressed word held before the operation. The usual use is lock and counter words shared between agents. A lock word holds 0 when free and 1 when held. An exchange of 1 or a test-and-set that returns 0 means the caller now owns the lock. Fetch-and-increment gives each caller a distinct ticket or queue slot.

Each accepted operation occupies exactly two memory cycles. The first cycle reads the word. The second cycle writes the new value, if the operation writes, and sends the answer back. A new operation is accepted only in a read cycle. No other request can therefore store to the memory between the read and the write of an atomic operation. Competing ports are served in round-robin order.

A port holds `req_valid` with its operation, address and operand until it sees its `done` bit. It may drop the request in that same cycle. If it keeps the request, that counts as a new operation.

Top module: `amo_rmw_unit`

## Requirements
- R1: After reset, `done` is all zero and every port's `rsp_data` slice is zero. With the default `CLEAR_ON_RESET=1`, every memory word reads as zero.
- R2: Op code 0 (load) returns the addressed word in `rsp_data` and leaves memory unchanged.
- R3: Op code 1 (store) writes the operand to the addressed word and returns the value it held before.
- R4: Op code 2 (exchange) writes the operand to the addressed word and returns the prior value.
- R5: Op code 3 (test-and-set) writes 1 to the addressed word and returns the prior value. A returned 0 means the lock was free and is now taken.
- R6: Op code 4 (fetch-and-increment) returns the prior value and stores that value plus one, modulo 2^WIDTH. All-ones becomes zero.
- R7: When several ports request at once, they are served in cyclic port order. The search starts at the port after the one served last, and at port 0 after reset.
- R8: Operations do not overlap. At most one `done` bit is high in any cycle. Each operation's write immediately follows its own read, so every operation sees the results of all operations served before it. When several ports test-and-set one free lock together, exactly one of them gets 0.
- R9: Op codes 5, 6 and 7 behave as a load: they return the word and do not write it.
- R10: `done` is a one-cycle pulse. A request presented to an idle unit before a rising edge gets its `done` after the second rising edge. Two successive `done` pulses are at least two cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NPORTS | Per-port request, held until that port's `done` |
| req_op | input | 3*NPORTS | Per-port op code, 3 bits per port; port p uses bits [3p+2:3p] |
| req_addr | input | ADDR_W*NPORTS | Per-port word address |
| req_data | input | WIDTH*NPORTS | Per-port operand for store and exchange |
| done | output | NPORTS | One-cycle completion pulse per port |
| rsp_data | output | WIDTH*NPORTS | Per-port prior value, held until that port's next completion |

## Verification
A fault in the phase sequence or in the latched operation shows up on the very next `done`. The returned prior value, or the value that a later load of the same word returns, differs from what a sequential model of memory predicts. A wrong arbitration pointer does not change any single value. It changes the order of `done` pulses among competing ports, and that shows within one round of concurrent requests. Lost atomicity is seen in a shared test-and-set. Either no port gets 0 or more than one port gets 0, in the same burst.

// File: rtl/amo_pkg.sv
package amo_pkg;

   localparam int OP_BITS = 3;

   typedef enum logic [OP_BITS-1:0] {
      AMO_LOAD  = 3'd0,
      AMO_STORE = 3'd1,
      AMO_SWAP  = 3'd2,
      AMO_TAS   = 3'd3,
      AMO_FINC  = 3'd4
   } amo_op_e;

   typedef enum logic {
      PH_READ  = 1'b0,
      PH_WRITE = 1'b1
   } amo_phase_e;

endpackage

// File: rtl/amo_rr_arbiter.sv
module amo_rr_arbiter #(
   parameter int NPORTS = 4,
   localparam int IW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPORTS-1:0] req,
   input  logic              advance,
   output logic [NPORTS-1:0] grant,
   output logic [IW-1:0]     grant_idx,
   output logic              any
);

   logic [IW-1:0] ptr_q;

   always_comb begin
      grant     = '0;
      grant_idx = '0;
      any       = 1'b0;
      for (int k = 0; k < NPORTS; k++) begin
         int c;
         c = int'(ptr_q) + k;
         if (c >= NPORTS) c = c - NPORTS;
         if (!any && req[c]) begin
            any       = 1'b1;
            grant[c]  = 1'b1;
            grant_idx = IW'(c);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (advance && any) begin
         if (int'(grant_idx) == NPORTS - 1) ptr_q <= '0;
         else                               ptr_q <= grant_idx + IW'(1);
      end
   end

endmodule

// File: rtl/amo_modify.sv
module amo_modify
   import amo_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic [OP_BITS-1:0] op,
   input  logic [WIDTH-1:0]   old_val,
   input  logic [WIDTH-1:0]   operand,
   output logic [WIDTH-1:0]   new_val,
   output logic               write_en
);

   always_comb begin
      new_val  = old_val;
      write_en = 1'b0;
      case (op)
         AMO_STORE, AMO_SWAP: begin
            new_val  = operand;
            write_en = 1'b1;
         end
         AMO_TAS: begin
            new_val  = WIDTH'(1);
            write_en = 1'b1;
         end
         AMO_FINC: begin
            new_val  = old_val + WIDTH'(1);
            write_en = 1'b1;
         end
         default: begin
            new_val  = old_val;
            write_en = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/amo_word_store.sv
module amo_word_store #(
   parameter int WIDTH          = 16,
   parameter int ADDR_W         = 4,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WIDTH-1:0]  wdata,
   output logic [WIDTH-1:0]  rdata
);

   logic [WIDTH-1:0] mem_q [DEPTH];

   generate
      if (CLEAR_ON_RESET) begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            end else if (en && we) begin
               mem_q[addr] <= wdata;
            end
         end
      end else begin : g_noclear
         always_ff @(posedge clk) begin
            if (en && we) mem_q[addr] <= wdata;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            rdata <= '0;
      else if (en && !we)    rdata <= mem_q[addr];
   end

endmodule

// File: rtl/amo_rmw_unit.sv
module amo_rmw_unit
   import amo_pkg::*;
#(
   parameter int NPORTS         = 4,
   parameter int WIDTH          = 16,
   parameter int ADDR_W         = 4,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NPORTS-1:0]          req_valid,
   input  logic [OP_BITS*NPORTS-1:0]  req_op,
   input  logic [ADDR_W*NPORTS-1:0]   req_addr,
   input  logic [WIDTH*NPORTS-1:0]    req_data,
   output logic [NPORTS-1:0]          done,
   output logic [WIDTH*NPORTS-1:0]    rsp_data
);

   localparam int IW = (NPORTS > 1) ? $clog2(NPORTS) : 1;

   generate
      if (NPORTS < 2)  begin : g_bad_ports $error("amo_rmw_unit: NPORTS must be at least 2"); end
      if (WIDTH < 2)   begin : g_bad_width $error("amo_rmw_unit: WIDTH must be at least 2"); end
      if (ADDR_W < 1)  begin : g_bad_addr  $error("amo_rmw_unit: ADDR_W must be at least 1"); end
   endgenerate

   amo_phase_e            phase_q;
   logic [NPORTS-1:0]     done_q;
   logic [WIDTH-1:0]      rsp_q [NPORTS];

   logic [IW-1:0]         cur_port_q;
   logic [OP_BITS-1:0]    cur_op_q;
   logic [ADDR_W-1:0]     cur_addr_q;
   logic [WIDTH-1:0]      cur_data_q;

   logic [NPORTS-1:0]     eligible;
   logic [NPORTS-1:0]     grant_vec;
   logic [IW-1:0]         grant_idx;
   logic                  grant_any;
   logic                  take;

   logic [OP_BITS-1:0]    sel_op;
   logic [ADDR_W-1:0]     sel_addr;
   logic [WIDTH-1:0]      sel_data;

   logic                  mem_en;
   logic                  mem_we;
   logic [ADDR_W-1:0]     mem_addr;
   logic [WIDTH-1:0]      mem_wdata;
   logic [WIDTH-1:0]      mem_rdata;
   logic                  mod_we;
   logic [WIDTH-1:0]      mod_val;
   logic                  phase_is_write;

   // a port whose completion is showing this cycle is not re-admitted yet
   assign eligible       = req_valid & ~done_q;
   assign phase_is_write = (phase_q == PH_WRITE);
   assign take           = !phase_is_write && grant_any;

   amo_rr_arbiter #(.NPORTS(NPORTS)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (phase_is_write ? '0 : eligible),
      .advance   (take),
      .grant     (grant_vec),
      .grant_idx (grant_idx),
      .any       (grant_any)
   );

   always_comb begin
      sel_op   = req_op  [grant_idx*OP_BITS +: OP_BITS];
      sel_addr = req_addr[grant_idx*ADDR_W  +: ADDR_W];
      sel_data = req_data[grant_idx*WIDTH   +: WIDTH];
   end

   amo_modify #(.WIDTH(WIDTH)) u_mod (
      .op       (cur_op_q),
      .old_val  (mem_rdata),
      .operand  (cur_data_q),
      .new_val  (mod_val),
      .write_en (mod_we)
   );

   always_comb begin
      if (phase_is_write) begin
         mem_en    = mod_we;
         mem_we    = mod_we;
         mem_addr  = cur_addr_q;
         mem_wdata = mod_val;
      end else begin
         mem_en    = take;
         mem_we    = 1'b0;
         mem_addr  = sel_addr;
         mem_wdata = '0;
      end
   end

   amo_word_store #(
      .WIDTH          (WIDTH),
      .ADDR_W         (ADDR_W),
      .CLEAR_ON_RESET (CLEAR_ON_RESET)
   ) u_mem (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (mem_en),
      .we    (mem_we),
      .addr  (mem_addr),
      .wdata (mem_wdata),
      .rdata (mem_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q    <= PH_READ;
         cur_port_q <= '0;
         cur_op_q   <= '0;
         cur_addr_q <= '0;
         cur_data_q <= '0;
         done_q     <= '0;
      end else begin
         done_q <= '0;
         if (phase_is_write) begin
            phase_q <= PH_READ;
            done_q  <= NPORTS'(1) << cur_port_q;
         end else if (take) begin
            phase_q    <= PH_WRITE;
            cur_port_q <= grant_idx;
            cur_op_q   <= sel_op;
            cur_addr_q <= sel_addr;
            cur_data_q <= sel_data;
         end
      end
   end

   generate
      for (genvar p = 0; p < NPORTS; p++) begin : g_rsp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   rsp_q[p] <= '0;
            else if (phase_is_write && int'(cur_port_q) == p) rsp_q[p] <= mem_rdata;
         end
         assign rsp_data[p*WIDTH +: WIDTH] = rsp_q[p];
      end
   endgenerate

   assign done = done_q;

endmodule

// File: rtl/amo_rmw_checker.sv
module amo_rmw_checker
   import amo_pkg::*;
#(
   parameter int NPORTS = 4,
   parameter int WIDTH  = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NPORTS-1:0]   req_valid,
   input logic [NPORTS-1:0]   done,
   input logic [NPORTS-1:0]   grant_vec,
   input logic                phase_is_write,
   input logic [OP_BITS-1:0]  cur_op_q,
   input logic                mem_en,
   input logic                mem_we,
   input logic [WIDTH-1:0]    mem_rdata,
   input logic [WIDTH-1:0]    mem_wdata
);

   AST_DONE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(done)); // R8

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (|done) |=> (done == '0)); // R10

   AST_DONE_AFTER_WRITE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      (|done) |-> $past(phase_is_write)); // R10

   AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> $past(mem_en && !mem_we)); // R8

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_vec)); // R7

   AST_GRANT_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
      ((grant_vec & ~req_valid) == '0)); // R7

   AST_TAS_WRITES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_is_write && cur_op_q == AMO_TAS) |-> (mem_we && mem_wdata == WIDTH'(1))); // R5

   AST_FINC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_is_write && cur_op_q == AMO_FINC) |-> (mem_we && mem_wdata == mem_rdata + WIDTH'(1))); // R6

   AST_LOAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_is_write && (cur_op_q == AMO_LOAD || cur_op_q > AMO_FINC)) |-> !mem_we); // R9

endmodule

bind amo_rmw_unit amo_rmw_checker #(.NPORTS(NPORTS), .WIDTH(WIDTH)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .req_valid      (req_valid),
   .done           (done),
   .grant_vec      (grant_vec),
   .phase_is_write (phase_is_write),
   .cur_op_q       (cur_op_q),
   .mem_en         (mem_en),
   .mem_we         (mem_we),
   .mem_rdata      (mem_rdata),
   .mem_wdata      (mem_wdata)
);

// File: tb/amo_rmw_unit_test.sv
module amo_rmw_unit_test;

   localparam int NP = 4;
   localparam int W  = 16;
   localparam int AW = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NP-1:0]     req_valid = '0;
   logic [3*NP-1:0]   req_op = '0;
   logic [AW*NP-1:0]  req_addr = '0;
   logic [W*NP-1:0]   req_data = '0;
   logic [NP-1:0]     done;
   logic [W*NP-1:0]   rsp_data;

   always #4 clk = ~clk;

   amo_rmw_unit #(.NPORTS(NP), .WIDTH(W), .ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_data(req_data), .done(done), .rsp_data(rsp_data)
   );

   typedef struct {
      int          port;
      logic [W-1:0] exp;
      string       tag;
   } item_t;

   item_t        sb_q[$];
   logic [W-1:0] mdl [1<<AW];
   int           last_served = NP - 1;
   int           vectors = 0;
   int           miscompares = 0;
   bit           finished = 0;

   task automatic predict(int p, int op, int a, logic [W-1:0] d, string tag);
      item_t it;
      it.port = p;
      it.exp  = mdl[a];
      it.tag  = tag;
      sb_q.push_back(it);
      case (op)
         1, 2:    mdl[a] = d;
         3:       mdl[a] = W'(1);
         4:       mdl[a] = mdl[a] + W'(1);
         default: ;
      endcase
      last_served = p;
   endtask

   task automatic drive(int p, int op, int a, logic [W-1:0] d);
      @(negedge clk);
      req_op[p*3 +: 3]    = 3'(op);
      req_addr[p*AW +: AW] = AW'(a);
      req_data[p*W +: W]  = d;
      req_valid[p]        = 1'b1;
      forever begin
         @(negedge clk);
         if (done[p]) break;
      end
      req_valid[p] = 1'b0;
   endtask

   task automatic run_op(int p, int op, int a, logic [W-1:0] d, string tag);
      predict(p, op, a, d, tag);
      drive(p, op, a, d);
   endtask

   task automatic check(bit ok, string tag, string what, int got, int exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
      end
   endtask

   // concurrent burst: ports in mask start together; order follows round robin
   task automatic burst(logic [NP-1:0] mask, int op[NP], int a[NP], logic [W-1:0] d[NP], string tag);
      int start;
      start = (last_served + 1) % NP;
      for (int k = 0; k < NP; k++) begin
         int p;
         p = (start + k) % NP;
         if (mask[p]) predict(p, op[p], a[p], d[p], tag);
      end
      fork
         begin if (mask[0]) drive(0, op[0], a[0], d[0]); end
         begin if (mask[1]) drive(1, op[1], a[1], d[1]); end
         begin if (mask[2]) drive(2, op[2], a[2], d[2]); end
         begin if (mask[3]) drive(3, op[3], a[3], d[3]); end
      join
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   // monitor: pops expected items as completions appear
   always @(negedge clk) begin
      if (rst_n) begin
         for (int p = 0; p < NP; p++) begin
            if (done[p]) begin
               if (sb_q.size() == 0) begin
                  check(1'b0, "R8", "unexpected done port", p, -1);
               end else begin
                  item_t it;
                  it = sb_q.pop_front();
                  check(it.port == p, it.tag, "completion order port", p, it.port);
                  check(rsp_data[p*W +: W] == it.exp, it.tag, "returned value",
                        int'(rsp_data[p*W +: W]), int'(it.exp));
               end
            end
         end
      end
   end

   initial begin
      #(8 * 150000);
      vectors++;
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      int op4[NP];
      int ad4[NP];
      logic [W-1:0] dt4[NP];
      int cnt;
      int zeros;

      for (int i = 0; i < (1<<AW); i++) mdl[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check(done == '0, "R1", "done after reset", int'(done), 0);
      check(rsp_data == '0, "R1", "rsp_data after reset", int'(rsp_data[W-1:0]), 0);

      // R3 store, R2 load
      run_op(0, 1, 3, 16'h1234, "R3");
      run_op(1, 0, 3, 16'h0000, "R2");
      run_op(2, 0, 3, 16'hFFFF, "R2");
      run_op(0, 0, 6, 16'h0000, "R1");

      // R4 exchange
      run_op(3, 2, 3, 16'hBEEF, "R4");
      run_op(0, 0, 3, 16'h0000, "R4");

      // R5 test-and-set
      run_op(1, 3, 5, 16'h0000, "R5");
      run_op(2, 3, 5, 16'h0000, "R5");
      run_op(3, 0, 5, 16'h0000, "R5");

      // R6 fetch-and-increment with wrap
      run_op(0, 4, 7, 16'h0000, "R6");
      run_op(0, 4, 7, 16'h0000, "R6");
      run_op(1, 4, 7, 16'h0000, "R6");
      run_op(2, 1, 8, 16'hFFFF, "R6");
      run_op(3, 4, 8, 16'h0000, "R6");
      run_op(0, 0, 8, 16'h0000, "R6");

      // R9 undefined codes read without writing
      run_op(1, 5, 3, 16'h0000, "R9");
      run_op(2, 6, 3, 16'h5555, "R9");
      run_op(3, 7, 3, 16'hAAAA, "R9");
      run_op(0, 0, 3, 16'h0000, "R9");

      // R8 four ports test-and-set one free lock together
      for (int p = 0; p < NP; p++) begin op4[p] = 3; ad4[p] = 9; dt4[p] = '0; end
      burst(4'b1111, op4, ad4, dt4, "R8");
      zeros = 0;
      for (int p = 0; p < NP; p++) if (rsp_data[p*W +: W] == '0) zeros++;
      check(zeros == 1, "R8", "lock winners", zeros, 1);

      // R7 partial set of ports, shared counter
      for (int p = 0; p < NP; p++) begin op4[p] = 4; ad4[p] = 10; dt4[p] = '0; end
      burst(4'b1010, op4, ad4, dt4, "R7");
      burst(4'b0111, op4, ad4, dt4, "R7");

      // R7 mixed operations from every port
      op4[0] = 2; ad4[0] = 11; dt4[0] = 16'h00A0;
      op4[1] = 4; ad4[1] = 11; dt4[1] = 16'h0000;
      op4[2] = 1; ad4[2] = 11; dt4[2] = 16'h0C0C;
      op4[3] = 0; ad4[3] = 11; dt4[3] = 16'h0000;
      burst(4'b1111, op4, ad4, dt4, "R7");
      run_op(1, 0, 11, 16'h0000, "R7");

      // R10 latency from an idle unit
      predict(2, 0, 10, 16'h0000, "R10");
      @(negedge clk);
      req_op[2*3 +: 3]     = 3'd0;
      req_addr[2*AW +: AW] = AW'(10);
      req_valid[2]         = 1'b1;
      cnt = 0;
      do begin
         @(negedge clk);
         cnt++;
      end while (!done[2] && cnt < 10);
      req_valid[2] = 1'b0;
      check(cnt == 2, "R10", "cycles to done", cnt, 2);
      @(negedge clk);
      check(done == '0, "R10", "done after pulse", int'(done), 0);

      repeat (3) @(negedge clk);
      check(sb_q.size() == 0, "R8", "outstanding expected items", sb_q.size(), 0);
      finish_run();
   end

endmodule